// File: doc/BRIEF.md
# Serial Status Flags with Sequenced Clearing

This block holds the condition flags of a serial communications interface and presents them as a 16-bit status word. The transmitter and receiver datapaths raise flags with single-cycle event pulses. The receiver busy indication is a live level that passes straight through to the word.

Software clears flags with a two-step bus sequence. It first reads the status register, and then it reads or writes the data register. The block records which flags were set at the moment of the status read in an arming mask. The later data access clears only flags that were armed. A flag that rises between the two steps therefore survives. A long-word read that starts at the status register and runs into the data register performs both steps in one access. That access clears only the receive-side flags that were set, and it leaves both transmit flags alone.

The register file uses byte addresses. The status register is at byte offsets 0 and 1, and the data register is at byte offsets 2 and 3. Addresses 4 to 7 belong to neighbouring registers.

Top module: `sflag_top`

## Requirements
- R1: After reset the status word reads 0x0180: transmit-empty (bit 8) and transmit-complete (bit 7) are 1, all other bits are 0, and bits 15..9 always read 0.
- R2: Each event pulse sets its flag on the next clock edge. The mapping is: transmit-empty to bit 8, transmit-complete to bit 7, receive-full to bit 6, idle-line to bit 4, noise to bit 2, framing to bit 1, parity to bit 0.
- R3: The overrun flag (bit 3) sets when a receive-full pulse arrives while bit 6 is already 1.
- R4: Bit 5 follows the receiver busy input in the same cycle. No bus sequence clears it.
- R5: A status read followed by a data-register read clears every flag that was set at the status read.
- R6: A data-register write completes the clearing sequence in the same way as a data-register read.
- R7: A flag that sets after the status read is not cleared by the following data access. It clears only after a new status read and a new data access.
- R8: A byte read at either status offset (0 or 1) arms all nine flags, including those in the other byte.
- R9: A long-word read (size code 2) at offset 0 clears the receive flags (bits 6, 4, 3, 2, 1, 0) that were set at that moment. It leaves bits 8 and 7 unchanged.
- R10: When an event pulse and a clearing access hit the same bit in the same cycle, the bit ends at 1.
- R11: A data access with no status read since the last clearing access clears nothing. An access at offsets 4 to 7 leaves the arming mask unchanged.
- R12: A write to the status register does not arm any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Bus access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Byte address within the register file |
| acc_size | input | 2 | Access size: 0 byte, 1 word, 2 long word |
| ev_tx_empty | input | 1 | Transmit holding register became empty |
| ev_tx_done | input | 1 | Transmitter went idle |
| ev_rx_full | input | 1 | New receive character arrived |
| ev_rx_idle | input | 1 | Idle line detected |
| ev_noise | input | 1 | Noise seen on a received character |
| ev_frame | input | 1 | Framing error |
| ev_parity | input | 1 | Parity error |
| rx_busy | input | 1 | Receiver is assembling a character |
| status_word | output | 16 | Status flags, bits 8..0 used |

## Verification
The assertions check on every cycle that:
- the unused upper bits stay zero and bit 5 tracks the busy input;
- an event pulse always leaves its flag set;
- overrun rises when a receive event meets a full register;
- a flag only ever drops in the cycle after a data access or a long-word status read;
- a long-word read never lowers either transmit flag.

Other behaviour depends on the history of bus accesses, so only the bench's scenarios can show it. This covers the arming window that lets a late flag survive, the difference between a status write and a status read, the upper-byte read that arms the lower byte, and a stray data access that clears nothing.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
  localparam int unsigned NFLAG  = 9;
  localparam int unsigned WORD_W = 16;

  localparam int unsigned B_TXE  = 8;
  localparam int unsigned B_TXC  = 7;
  localparam int unsigned B_RXF  = 6;
  localparam int unsigned B_BUSY = 5;
  localparam int unsigned B_IDL  = 4;
  localparam int unsigned B_OVR  = 3;
  localparam int unsigned B_NSE  = 2;
  localparam int unsigned B_FRM  = 1;
  localparam int unsigned B_PAR  = 0;

  localparam logic [NFLAG-1:0] RST_FLAGS = 9'b1_1000_0000;
  localparam logic [NFLAG-1:0] RX_CLR    = 9'b0_0101_1111;
  localparam logic [NFLAG-1:0] ALL_CLR   = 9'b1_1101_1111;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/sflag_rst_sync.sv
module sflag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sflag_decode.sv
module sflag_decode
  import sflag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned STAT_OFS = 0,
  parameter int unsigned DATA_OFS = 2
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  output logic              stat_rd,
  output logic              long_rd,
  output logic              data_acc
);
  localparam logic [ADDR_W-2:0] STAT_W = (ADDR_W-1)'(STAT_OFS >> 1);
  localparam logic [ADDR_W-2:0] DATA_W = (ADDR_W-1)'(DATA_OFS >> 1);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  acc_size_e size_e;
  logic      hit_stat;
  logic      hit_data;
  logic      is_long_at_stat;

  always_comb begin
    size_e          = acc_size_e'(acc_size);
    hit_stat        = acc_valid && (acc_addr[ADDR_W-1:1] == STAT_W);
    is_long_at_stat = acc_valid && (size_e == SZ_LONG) && (acc_addr == STAT_A);
    hit_data        = acc_valid && ((acc_addr[ADDR_W-1:1] == DATA_W) || is_long_at_stat);
    stat_rd         = hit_stat && !acc_write;
    long_rd         = is_long_at_stat && !acc_write;
    data_acc        = hit_data && !long_rd;
  end
endmodule

// File: rtl/sflag_cell.sv
module sflag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i || clr_i;
    q_d  = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RST_VAL;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/sflag_top.sv
module sflag_top
  import sflag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned STAT_OFS = 0,
  parameter int unsigned DATA_OFS = 2,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [1:0]         acc_size,
  input  logic               ev_tx_empty,
  input  logic               ev_tx_done,
  input  logic               ev_rx_full,
  input  logic               ev_rx_idle,
  input  logic               ev_noise,
  input  logic               ev_frame,
  input  logic               ev_parity,
  input  logic               rx_busy,
  output logic [WORD_W-1:0]  status_word
);
  localparam int unsigned PAD_W = WORD_W - NFLAG;

  logic             rst_sync_n;
  logic             stat_rd;
  logic             long_rd;
  logic             data_acc;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] arm_q;
  logic [NFLAG-1:0] arm_d;
  logic             arm_en;

  sflag_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sflag_decode #(
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .DATA_OFS (DATA_OFS)
  ) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .stat_rd   (stat_rd),
    .long_rd   (long_rd),
    .data_acc  (data_acc)
  );

  // Event pulses into per-bit set requests; overrun needs a full register.
  always_comb begin
    set_vec         = '0;
    set_vec[B_TXE]  = ev_tx_empty;
    set_vec[B_TXC]  = ev_tx_done;
    set_vec[B_RXF]  = ev_rx_full;
    set_vec[B_IDL]  = ev_rx_idle;
    set_vec[B_OVR]  = ev_rx_full && flags[B_RXF];
    set_vec[B_NSE]  = ev_noise;
    set_vec[B_FRM]  = ev_frame;
    set_vec[B_PAR]  = ev_parity;
  end

  // A long read arms and clears receive flags in one step.
  always_comb begin
    if (long_rd)       clr_vec = flags & RX_CLR;
    else if (data_acc) clr_vec = arm_q & ALL_CLR;
    else               clr_vec = '0;
  end

  // Arming mask next state.
  always_comb begin
    arm_en = long_rd || stat_rd || data_acc;
    if (long_rd)      arm_d = '0;
    else if (stat_rd) arm_d = flags;
    else              arm_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  arm_q <= '0;
    else if (arm_en)  arm_q <= arm_d;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    if (i == B_BUSY) begin : g_live
      assign flags[i] = rx_busy;
    end else begin : g_cell
      sflag_cell #(.RST_VAL(RST_FLAGS[i])) u_cell (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .set_i (set_vec[i]),
        .clr_i (clr_vec[i]),
        .q_o   (flags[i])
      );
    end
  end

  assign status_word = {{PAD_W{1'b0}}, flags};
endmodule

// File: rtl/sflag_chk.sv
module sflag_chk
  import sflag_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_size,
  input logic              ev_tx_empty,
  input logic              ev_tx_done,
  input logic              ev_rx_full,
  input logic              ev_rx_idle,
  input logic              ev_noise,
  input logic              ev_frame,
  input logic              ev_parity,
  input logic              rx_busy,
  input logic [WORD_W-1:0] status_word
);
  logic [NFLAG-1:0] ev_bits;
  logic             lr_seen;
  logic             clr_seen;

  assign ev_bits = {ev_tx_empty, ev_tx_done, ev_rx_full, 1'b0, ev_rx_idle,
                    1'b0, ev_noise, ev_frame, ev_parity};
  assign lr_seen  = acc_valid && !acc_write && (acc_size == 2'd2) && (acc_addr == '0);
  assign clr_seen = acc_valid && ((acc_addr[ADDR_W-1:1] == 1) || (acc_size == 2'd2 && acc_addr == '0));

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[WORD_W-1:NFLAG] == '0);

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bits != '0) |=> ((status_word[NFLAG-1:0] & $past(ev_bits)) == $past(ev_bits)));

  p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_full && status_word[B_RXF]) |=> status_word[B_OVR]);

  p_busy_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[B_BUSY] == rx_busy);

  // R5: a stored flag only drops after a clearing access
  p_fall_needs_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_word[NFLAG-1:0]) & ~status_word[NFLAG-1:0] & ALL_CLR) != '0)
      |-> $past(clr_seen));

  p_long_keeps_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lr_seen |=> (status_word[B_TXE] >= $past(status_word[B_TXE]))
             && (status_word[B_TXC] >= $past(status_word[B_TXC])));
endmodule

bind sflag_top sflag_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sflag_top_bench.sv
module sflag_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [2:0]  acc_addr;
  logic [1:0]  acc_size;
  logic        ev_tx_empty, ev_tx_done, ev_rx_full, ev_rx_idle;
  logic        ev_noise, ev_frame, ev_parity, rx_busy;
  logic [15:0] status_word;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  sflag_top u_sflag_top (.*);

  task automatic check(input string req, input logic [15:0] exp);
    total++;
    if (status_word !== exp) begin
      bad++;
      $display("FAIL %s: status=0x%04h expected 0x%04h", req, status_word, exp);
    end
  endtask

  // one-cycle stimulus: access plus optional events
  task automatic cyc(input logic v, input logic w, input logic [2:0] a,
                     input logic [1:0] s, input logic [8:0] ev);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_addr = a; acc_size = s;
    {ev_tx_empty, ev_tx_done, ev_rx_full} = ev[8:6];
    ev_rx_idle = ev[4];
    {ev_noise, ev_frame, ev_parity} = ev[2:0];
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    {ev_tx_empty, ev_tx_done, ev_rx_full, ev_rx_idle, ev_noise, ev_frame, ev_parity} = '0;
  endtask

  task automatic pulse(input logic [8:0] ev);  cyc(1'b0, 1'b0, 3'd0, 2'd0, ev); endtask
  task automatic rd(input logic [2:0] a, input logic [1:0] s); cyc(1'b1, 1'b0, a, s, 9'd0); endtask
  task automatic wr(input logic [2:0] a, input logic [1:0] s); cyc(1'b1, 1'b1, a, s, 9'd0); endtask
  task automatic wipe(); rd(3'd0, 2'd1); rd(3'd2, 2'd1); endtask

  task automatic t_reset();
    check("R1", 16'h0180);
    rd(3'd0, 2'd1); wr(3'd2, 2'd1);
    check("R6", 16'h0000);
  endtask

  task automatic t_events();
    pulse(9'h1D7);
    check("R2", 16'h01D7);
    pulse(9'h040);
    check("R3", 16'h01DF);
    rd(3'd0, 2'd1); rd(3'd2, 2'd0);
    check("R5", 16'h0000);
  endtask

  task automatic t_busy();
    @(negedge clk); rx_busy = 1'b1; #1;
    check("R4", 16'h0020);
    wipe();
    check("R4", 16'h0020);
    @(negedge clk); rx_busy = 1'b0; #1;
    check("R4", 16'h0000);
  endtask

  task automatic t_late();
    pulse(9'h040);
    rd(3'd0, 2'd1);
    pulse(9'h004);
    check("R7", 16'h0044);
    rd(3'd2, 2'd1);
    check("R7", 16'h0004);
    rd(3'd2, 2'd1);
    check("R11", 16'h0004);
    wipe();
    check("R7", 16'h0000);
  endtask

  task automatic t_upper_byte();
    pulse(9'h101);
    rd(3'd1, 2'd0); rd(3'd3, 2'd0);
    check("R8", 16'h0000);
  endtask

  task automatic t_other_reg();
    pulse(9'h010);
    rd(3'd0, 2'd1); rd(3'd4, 2'd1); wr(3'd6, 2'd0);
    rd(3'd2, 2'd1);
    check("R11", 16'h0000);
  endtask

  task automatic t_stat_write();
    pulse(9'h002);
    wr(3'd0, 2'd1); rd(3'd2, 2'd1);
    check("R12", 16'h0002);
    wipe();
    check("R12", 16'h0000);
  endtask

  task automatic t_long();
    pulse(9'h1C2);
    rd(3'd0, 2'd2);
    check("R9", 16'h0180);
    rd(3'd2, 2'd1);
    check("R9", 16'h0180);
    rd(3'd0, 2'd1); wr(3'd2, 2'd1);
    check("R9", 16'h0000);
  endtask

  task automatic t_collide();
    pulse(9'h040);
    rd(3'd0, 2'd1);
    cyc(1'b1, 1'b0, 3'd2, 2'd1, 9'h040);
    check("R10", 16'h0048);
    wipe();
    check("R10", 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_size = '0;
    {ev_tx_empty, ev_tx_done, ev_rx_full, ev_rx_idle, ev_noise, ev_frame, ev_parity} = '0;
    rx_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_events();
    t_busy();
    t_late();
    t_upper_byte();
    t_other_reg();
    t_stat_write();
    t_long();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: done=%0b expected 1", done);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule